// File: doc/BRIEF.md
# Opcode Fetch and Program-Counter Advance Sequencer

This block drives the first two cycles of every instruction in a small byte-wide processor. In the first cycle it puts the program counter on the read address, captures the returned byte into the instruction register and steps the counter. In the second cycle it again reads at the counter. That read always happens, because the opcode has not been decoded when the cycle is set up. A cheap bit-pattern test on the captured opcode then decides whether the counter also steps past that byte. If it does not, the byte will be read again as the next opcode.

An interrupt request is sampled at the end of the second cycle, so it lands on an instruction boundary. When it is honoured, the next opcode cycle writes the break opcode (zero) into the instruction register in place of the memory byte. A separate inhibit blocks the counter step in both cycles, so the address of the interrupted instruction is kept. A one-cycle strobe, together with a flag, tells later pipeline stages whether the second byte was consumed.

Top module: `opfetch_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `ir_o` to 0x00, loads `pc_o` from `rst_vec`, drops `step_done` and `int_entry`, clears any pending interrupt and leaves the block in the opcode cycle.
- R2: `mem_addr` equals `pc_o` in both cycles. In the second cycle of a normal instruction it is the opcode address plus one, so the following byte is always read.
- R3: In an opcode cycle with no pending interrupt, the edge writes `mem_rdata` into `ir_o` and adds one to `pc_o`.
- R4: An opcode with bit 3 = 1, bit 2 = 0 and bit 0 = 0 (`(op & 0x0D) == 0x08`) is single-byte. Its second cycle leaves `pc_o` unchanged and reports `arg_used` = 0.
- R5: Every other opcode, including the break opcode 0x00 fetched from memory, adds one to `pc_o` in the second cycle and reports `arg_used` = 1.
- R6: When `irq_req` is high at the edge that ends a second cycle, the following opcode cycle writes 0x00 into `ir_o`. `pc_o` does not change in that opcode cycle or in the second cycle after it. `int_entry` is high during that second cycle, and `arg_used` reports 0.
- R7: `irq_req` is ignored at the edge that ends an opcode cycle. A pulse present only then is not taken.
- R8: `pc_o` wraps from 0xFFFF to 0x0000 on a step.
- R9: `step_done` is high for exactly the one cycle after each second cycle, and `arg_used` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rst_vec | input | 16 | Start address loaded by reset |
| irq_req | input | 1 | Interrupt request level |
| mem_rdata | input | 8 | Byte returned from memory for `mem_addr` |
| mem_addr | output | 16 | Read address, equal to the program counter |
| pc_o | output | 16 | Program counter |
| ir_o | output | 8 | Instruction register |
| arg_used | output | 1 | Second byte consumed by the last instruction |
| step_done | output | 1 | One-cycle strobe after each second cycle |
| int_entry | output | 1 | High in the second cycle of an interrupt entry |

## Verification
A wrong phase register shows up on `step_done` at once: it either stops alternating or lands one cycle late, and the address of the next opcode fetch moves with it. A faulty single-byte decode or a lost inhibit bit leaves `pc_o` off by one at the very next `step_done`, and the error stays in every later fetch address. A pending-interrupt flag held too long, or sampled at the wrong edge, gives a zero in `ir_o` for an instruction that should have run normally, or no zero where one was due.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

   typedef enum logic {
      PH_OPCODE = 1'b0,
      PH_ARG    = 1'b1
   } phase_e;

   localparam int unsigned DEF_PC_W     = 16;
   localparam int unsigned DEF_OP_W     = 8;
   localparam logic [7:0]  DEF_SB_MASK  = 8'h0D;
   localparam logic [7:0]  DEF_SB_MATCH = 8'h08;
   localparam logic [7:0]  DEF_BRK_OP   = 8'h00;

endpackage

// File: rtl/opfetch_phase.sv
module opfetch_phase
   import opfetch_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   irq_req,
   output phase_e phase,
   output logic   irq_pend,
   output logic   inhibit_q,
   output logic   step_done
);

   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q   <= PH_OPCODE;
         irq_pend  <= 1'b0;
         inhibit_q <= 1'b0;
         step_done <= 1'b0;
      end else begin
         phase_q   <= (phase_q == PH_OPCODE) ? PH_ARG : PH_OPCODE;
         // sample only at the instruction boundary
         irq_pend  <= (phase_q == PH_ARG) ? irq_req : 1'b0;
         // carry the honoured interrupt into the second cycle
         inhibit_q <= (phase_q == PH_OPCODE) ? irq_pend : 1'b0;
         step_done <= (phase_q == PH_ARG);
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/opfetch_decode.sv
module opfetch_decode #(
   parameter int unsigned     OP_W     = 8,
   parameter logic [OP_W-1:0] SB_MASK  = 8'h0D,
   parameter logic [OP_W-1:0] SB_MATCH = 8'h08,
   parameter bit              SB_EN    = 1'b1
) (
   input  logic [OP_W-1:0] op,
   output logic            single
);

   generate
      if (SB_EN) begin : g_pattern
         logic [OP_W-1:0] bit_ok;
         for (genvar b = 0; b < OP_W; b++) begin : g_bit
            if (SB_MASK[b]) begin : g_care
               assign bit_ok[b] = (op[b] == SB_MATCH[b]);
            end else begin : g_dont
               assign bit_ok[b] = 1'b1;
            end
         end
         assign single = &bit_ok;
      end else begin : g_none
         logic unused_op;
         assign unused_op = ^op;
         assign single    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/opfetch_pc.sv
module opfetch_pc #(
   parameter int unsigned PC_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] rst_vec,
   input  logic            step,
   output logic [PC_W-1:0] pc
);

   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   always_ff @(posedge clk) begin
      if (rst)
         pc <= rst_vec;
      else if (step)
         pc <= pc + ONE;
   end

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
   import opfetch_pkg::*;
#(
   parameter int unsigned     PC_W     = DEF_PC_W,
   parameter int unsigned     OP_W     = DEF_OP_W,
   parameter logic [OP_W-1:0] SB_MASK  = DEF_SB_MASK,
   parameter logic [OP_W-1:0] SB_MATCH = DEF_SB_MATCH,
   parameter logic [OP_W-1:0] BRK_OP   = DEF_BRK_OP,
   parameter bit              SB_EN    = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] rst_vec,
   input  logic            irq_req,
   input  logic [OP_W-1:0] mem_rdata,
   output logic [PC_W-1:0] mem_addr,
   output logic [PC_W-1:0] pc_o,
   output logic [OP_W-1:0] ir_o,
   output logic            arg_used,
   output logic            step_done,
   output logic            int_entry
);

   generate
      if (PC_W < 2) begin : g_bad_pc
         $error("opfetch_seq: PC_W must be at least 2");
      end
      if (OP_W < 4) begin : g_bad_op
         $error("opfetch_seq: OP_W must be at least 4");
      end
      if ((SB_MATCH & ~SB_MASK) != '0) begin : g_bad_pat
         $error("opfetch_seq: SB_MATCH has bits outside SB_MASK");
      end
   endgenerate

   phase_e          phase;
   logic            irq_pend;
   logic            inhibit_q;
   logic            single;
   logic            pc_step;
   logic            arg_adv;
   logic [OP_W-1:0] ir_q;
   logic            used_q;
   logic [PC_W-1:0] pc_q;

   opfetch_phase u_phase (
      .clk       (clk),
      .rst       (rst),
      .irq_req   (irq_req),
      .phase     (phase),
      .irq_pend  (irq_pend),
      .inhibit_q (inhibit_q),
      .step_done (step_done)
   );

   opfetch_decode #(
      .OP_W     (OP_W),
      .SB_MASK  (SB_MASK),
      .SB_MATCH (SB_MATCH),
      .SB_EN    (SB_EN)
   ) u_dec (
      .op     (ir_q),
      .single (single)
   );

   // second-cycle step: blocked by the single-byte decode or the interrupt inhibit
   assign arg_adv = !single && !inhibit_q;

   always_comb begin
      unique case (phase)
         PH_OPCODE: pc_step = !irq_pend;
         PH_ARG:    pc_step = arg_adv;
         default:   pc_step = 1'b0;
      endcase
   end

   opfetch_pc #(
      .PC_W (PC_W)
   ) u_pc (
      .clk     (clk),
      .rst     (rst),
      .rst_vec (rst_vec),
      .step    (pc_step),
      .pc      (pc_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q   <= '0;
         used_q <= 1'b0;
      end else if (phase == PH_OPCODE) begin
         ir_q   <= irq_pend ? BRK_OP : mem_rdata;
      end else begin
         used_q <= arg_adv;
      end
   end

   assign mem_addr  = pc_q;
   assign pc_o      = pc_q;
   assign ir_o      = ir_q;
   assign arg_used  = used_q;
   assign int_entry = inhibit_q;

endmodule

// File: rtl/opfetch_chk.sv
module opfetch_chk #(
   parameter int unsigned     PC_W     = 16,
   parameter int unsigned     OP_W     = 8,
   parameter logic [OP_W-1:0] SB_MASK  = 8'h0D,
   parameter logic [OP_W-1:0] SB_MATCH = 8'h08
) (
   input logic            clk,
   input logic            rst,
   input logic [PC_W-1:0] rst_vec,
   input logic [PC_W-1:0] pc_o,
   input logic [OP_W-1:0] ir_o,
   input logic            arg_used,
   input logic            step_done,
   input logic            int_entry
);

   AST_RESET_LOADS: assert property (@(posedge clk)
      rst |=> (ir_o == '0 && pc_o == $past(rst_vec) && !step_done)); // R1

   AST_SINGLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (step_done && ((ir_o & SB_MASK) == SB_MATCH)) |-> (!arg_used && pc_o == $past(pc_o))); // R4

   AST_MULTI_STEPS: assert property (@(posedge clk) disable iff (rst)
      (step_done && arg_used) |-> (pc_o == PC_W'($past(pc_o) + 1'b1))); // R5

   AST_IRQ_FROZEN: assert property (@(posedge clk) disable iff (rst)
      $rose(int_entry) |-> (ir_o == '0 && pc_o == $past(pc_o))); // R6

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      step_done |=> !step_done); // R9

endmodule

bind opfetch_seq opfetch_chk #(
   .PC_W     (PC_W),
   .OP_W     (OP_W),
   .SB_MASK  (SB_MASK),
   .SB_MATCH (SB_MATCH)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rst_vec   (rst_vec),
   .pc_o      (pc_o),
   .ir_o      (ir_o),
   .arg_used  (arg_used),
   .step_done (step_done),
   .int_entry (int_entry)
);

// File: tb/sim_opfetch_seq.sv
module sim_opfetch_seq;

   typedef struct {
      logic [15:0] pc;
      logic [7:0]  ir;
      logic        used;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] rst_vec = 16'h1000;
   logic        irq_req = 1'b0;
   logic [7:0]  mem_rdata = 8'h00;
   logic [15:0] mem_addr;
   logic [15:0] pc_o;
   logic [7:0]  ir_o;
   logic        arg_used;
   logic        step_done;
   logic        int_entry;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t sb_q[$];
   logic [15:0] pc_m;
   logic        pend_m;

   always #10ns clk = ~clk;

   opfetch_seq u0 (
      .clk       (clk),
      .rst       (rst),
      .rst_vec   (rst_vec),
      .irq_req   (irq_req),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .pc_o      (pc_o),
      .ir_o      (ir_o),
      .arg_used  (arg_used),
      .step_done (step_done),
      .int_entry (int_entry)
   );

   function automatic logic is_single(input logic [7:0] op);
      return (op & 8'h0D) == 8'h08;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops one expected item per completion strobe
   always @(negedge clk) begin
      if (!rst && step_done) begin
         if (sb_q.size() == 0) begin
            check("R9 unexpected strobe", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check("R3/R4/R5/R6 pc", {16'h0, pc_o}, {16'h0, e.pc});
            check("R3/R6 ir", {24'h0, ir_o}, {24'h0, e.ir});
            check("R4/R5/R6 arg_used", {31'h0, arg_used}, {31'h0, e.used});
         end
      end
   end

   // entered at a negedge inside a reset cycle; leaves at the negedge of the first opcode cycle
   task automatic do_reset(input logic [15:0] v);
      rst = 1'b1;
      rst_vec = v;
      irq_req = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R1 ir", {24'h0, ir_o}, 32'h0);
      check("R1 pc", {16'h0, pc_o}, {16'h0, v});
      check("R1 step_done", {31'h0, step_done}, 32'h0);
      check("R1 int_entry", {31'h0, int_entry}, 32'h0);
      sb_q.delete();
      pc_m = v;
      pend_m = 1'b0;
      rst = 1'b0;
   endtask

   // driver: entered at a negedge in an opcode cycle
   task automatic run_instr(input logic [7:0] op, input logic irq_next, input logic glitch);
      logic taken;
      logic [7:0] exp_ir;
      logic adv;
      exp_t e;
      check("R2 opcode address", {16'h0, mem_addr}, {16'h0, pc_m});
      mem_rdata = op;
      irq_req = glitch;
      taken = pend_m;
      exp_ir = taken ? 8'h00 : op;
      if (!taken) pc_m = pc_m + 16'h1;
      @(posedge clk);
      @(negedge clk);
      check("R2 second byte address", {16'h0, mem_addr}, {16'h0, pc_m});
      check("R6 int_entry", {31'h0, int_entry}, {31'h0, taken});
      mem_rdata = ~op;
      irq_req = irq_next;
      adv = !taken && !is_single(exp_ir);
      if (adv) pc_m = pc_m + 16'h1;
      pend_m = irq_next;
      e.pc = pc_m;
      e.ir = exp_ir;
      e.used = adv;
      sb_q.push_back(e);
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20ns * 50000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset(16'h1000);                          // R1
      for (int i = 0; i < 256; i++)
         run_instr(8'(i), 1'b0, 1'b0);             // R3 R4 R5 all opcodes
      run_instr(8'h00, 1'b0, 1'b0);                // R5 break opcode from memory
      run_instr(8'hEA, 1'b1, 1'b0);                // request interrupt at boundary
      run_instr(8'h20, 1'b0, 1'b0);                // R6 taken: ir zero, pc frozen
      run_instr(8'h20, 1'b0, 1'b0);                // same address fetched again
      run_instr(8'h18, 1'b1, 1'b0);
      run_instr(8'hA9, 1'b1, 1'b0);                // R6 taken, next one pending again
      run_instr(8'hA9, 1'b0, 1'b0);                // R6 back-to-back entry
      run_instr(8'hA9, 1'b0, 1'b0);
      run_instr(8'h4C, 1'b0, 1'b1);                // R7 pulse only in opcode cycle
      run_instr(8'hA9, 1'b0, 1'b0);                // R7 must run normally
      do_reset(16'hFFFF);
      run_instr(8'h01, 1'b0, 1'b0);                // R8 wrap through both steps
      do_reset(16'hFFFF);
      run_instr(8'h0A, 1'b0, 1'b0);                // R8 wrap then R4 hold
      run_instr(8'h48, 1'b0, 1'b0);
      rst = 1'b1;                                  // reset in the middle of a run
      do_reset(16'h2345);                          // R1
      run_instr(8'h6D, 1'b0, 1'b0);
      @(negedge clk);
      check("R9 strobe is one cycle", {31'h0, step_done}, 32'h0);
      check("R9 queue drained", sb_q.size(), 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule